// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. The program counter, the register file and both memories are updated together on the rising clock edge. Everything in between is combinational: instruction fetch, operand read, immediate extension, ALU, data memory read and write-back selection all settle within the same cycle. Six instructions are decoded: register add and register subtract (both wrap silently), OR with an unsigned immediate, word load, word store, and branch on equal. Any other encoding retires as a no-op.

The instruction memory is filled through a program port, normally while reset is held. After reset is released the core runs from byte address 0. A trace of each cycle is visible on the outputs: the program counter, the register write strobe with its address and data, and the data memory write strobe with its address and data.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and neither rf_we_o nor dm_we_o is asserted; execution starts at byte address 0 once reset is released.
- R2: Opcode 0x00 with function 0x21 writes the 32-bit sum of registers rs[25:21] and rt[20:16], modulo 2^32, to register rd[15:11] and advances the PC by 4.
- R3: Opcode 0x00 with function 0x23 writes rs minus rt, modulo 2^32, to register rd and advances the PC by 4.
- R4: Opcode 0x0D writes rs OR the zero-extended imm[15:0] to register rt and advances the PC by 4.
- R5: Opcode 0x23 writes the data memory word at rs plus sign-extended imm to register rt. A load sees every store retired in earlier cycles.
- R6: Opcode 0x2B writes register rt to data memory at rs plus sign-extended imm, asserts no register write, and advances the PC by 4.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended imm shifted left by 2; otherwise it is PC+4. The instruction writes neither a register nor memory.
- R8: Register 0 always reads as zero. A write that targets it is shown on the trace but leaves no value behind.
- R9: Any other opcode, and opcode 0x00 with any other function, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prog_we_i | input | 1 | Instruction memory write strobe |
| prog_addr_i | input | 6 | Instruction memory word index |
| prog_data_i | input | 32 | Instruction word to store |
| pc_o | output | 32 | Byte address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write in this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Value written back |
| dm_we_o | output | 1 | Data memory write in this cycle |
| dm_addr_o | output | 32 | Effective data address (ALU result) |
| dm_wdata_o | output | 32 | Store data (register rt) |

## Verification
The assertions assume that the program counter stays inside the instruction memory, that data addresses are word-aligned and fall inside the data memory, and that the program port is written only while reset is low. The stimulus respects all three. Each program is loaded under reset, every effective address is an aligned address below 256, and every program ends in a branch-to-self, so the PC never leaves the loaded words. Loads read only words that were stored earlier, so no load returns uninitialised memory.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_OR  = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;     // 1: rd, 0: rt
    logic    alu_src;     // 1: extended immediate
    logic    ext_sign;    // 1: sign extend
    logic    mem_to_reg;
    logic    reg_wr;
    logic    mem_wr;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    case (op_i)
      OP_RTYPE: begin
        case (funct_i)
          FN_ADDU: begin
            ctrl_o.reg_dst = 1'b1;
            ctrl_o.reg_wr  = 1'b1;
          end
          FN_SUBU: begin
            ctrl_o.reg_dst = 1'b1;
            ctrl_o.reg_wr  = 1'b1;
            ctrl_o.alu_op  = ALU_SUB;
          end
          default: ;
        endcase
      end
      OP_ORI: begin
        ctrl_o.alu_src = 1'b1;
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.ext_sign   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_wr     = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src  = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.mem_wr   = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.ext_sign = 1'b1;   // offset for the branch adder
        ctrl_o.branch   = 1'b1;
        ctrl_o.alu_op   = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] y_o,
  output logic             zero_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  // R8
  r0_read_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o == '0));
  // R8
  r0_read_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned WORDS = 64,   // power of two
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R6
  mem_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64,
  parameter int unsigned NREGS      = 32,
  localparam int unsigned XLEN      = 32,
  localparam int unsigned IAW       = $clog2(IMEM_WORDS),
  localparam int unsigned DAW       = $clog2(DMEM_WORDS),
  localparam int unsigned RAW       = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_we_i,
  input  logic [IAW-1:0]  prog_addr_i,
  input  logic [XLEN-1:0] prog_data_i,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_off;
  logic [XLEN-1:0] instr, imm_ext, alu_b, alu_y, rd_a, rd_b, dm_rdata, wb_data;
  logic [5:0]      op, funct;
  logic [RAW-1:0]  rs, rt, rd, rw;
  logic [15:0]     imm;
  logic            alu_zero, br_taken, rf_we, dm_we;
  ctrl_t           ctrl;

  // fetch
  sc_mem #(.WIDTH(XLEN), .WORDS(IMEM_WORDS)) i_imem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc_q[IAW+1:2]),
    .rdata_o (instr)
  );

  assign op    = instr[31:26];
  assign rs    = instr[21+RAW-1:21];
  assign rt    = instr[16+RAW-1:16];
  assign rd    = instr[11+RAW-1:11];
  assign funct = instr[5:0];
  assign imm   = instr[15:0];

  sc_decode i_decode (
    .op_i    (op),
    .funct_i (funct),
    .ctrl_o  (ctrl)
  );

  assign rw      = ctrl.reg_dst ? rd : rt;
  assign imm_ext = ctrl.ext_sign ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  assign rf_we   = ctrl.reg_wr & rst_ni;
  assign dm_we   = ctrl.mem_wr & rst_ni;

  sc_regfile #(.WIDTH(XLEN), .NREGS(NREGS)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rw),
    .wdata_i   (wb_data),
    .raddr_a_i (rs),
    .raddr_b_i (rt),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rd_b;

  sc_alu #(.WIDTH(XLEN)) i_alu (
    .a_i    (rd_a),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  sc_mem #(.WIDTH(XLEN), .WORDS(DMEM_WORDS)) i_dmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dm_we),
    .waddr_i (alu_y[DAW+1:2]),
    .wdata_i (rd_b),
    .raddr_i (alu_y[DAW+1:2]),
    .rdata_o (dm_rdata)
  );

  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  // next PC
  assign br_taken = ctrl.branch & alu_zero;
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_off   = {imm_ext[XLEN-3:0], 2'b00};
  assign pc_next  = br_taken ? (pc_plus4 + br_off) : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = rw;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rd_b;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], instr[25:21+RAW], instr[20:16+RAW], instr[15:11+RAW],
                         pc_q[1:0], pc_q[XLEN-1:IAW+2], alu_y[1:0], alu_y[XLEN-1:DAW+2],
                         imm_ext[XLEN-1:XLEN-2]};

  // R9
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_taken |=> (pc_q == $past(pc_q) + XLEN'(4)));
  // R7
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (!dm_we_o && !rf_we_o));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc, rf_wdata, dm_addr, dm_wdata;
  logic [4:0]  rf_waddr;
  logic        rf_we, dm_we;

  always #10 clk = ~clk;   // 50 MHz

  sc_core i_sc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .prog_we_i   (prog_we),
    .prog_addr_i (prog_addr),
    .prog_data_i (prog_data),
    .pc_o        (pc),
    .rf_we_o     (rf_we),
    .rf_waddr_o  (rf_waddr),
    .rf_wdata_o  (rf_wdata),
    .dm_we_o     (dm_we),
    .dm_addr_o   (dm_addr),
    .dm_wdata_o  (dm_wdata)
  );

  typedef struct {
    logic [31:0] pc;
    logic        rf_we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        dm_we;
    logic [31:0] da;
    logic [31:0] dd;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] prog[$];
  logic [31:0] m_regs [32];
  logic [31:0] m_dmem [64];
  int          vec_cnt = 0;
  int          err_cnt = 0;
  bit          mon_en = 1'b0;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model: builds the expected per-cycle trace
  task automatic model_run(int cycles);
    logic [31:0] mpc = 0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    for (int c = 0; c < cycles; c++) begin
      exp_t        e;
      logic [31:0] w, a, b, sx, zx, ea;
      int          rs, rt, rd;
      w  = prog[mpc >> 2];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      a  = m_regs[rs];     b  = m_regs[rt];
      sx = {{16{w[15]}}, w[15:0]};
      zx = {16'h0, w[15:0]};
      ea = a + sx;
      e = '{pc: mpc, rf_we: 0, wa: 0, wd: 0, dm_we: 0, da: 0, dd: 0, tag: "R9"};
      mpc = mpc + 4;
      case (w[31:26])
        6'h00: begin
          if (w[5:0] == 6'h21 || w[5:0] == 6'h23) begin
            e.rf_we = 1; e.wa = 5'(rd);
            e.wd  = (w[5:0] == 6'h21) ? a + b : a - b;
            e.tag = (rd == 0 || rs == 0) ? "R8" : (w[5:0] == 6'h21 ? "R2" : "R3");
          end
        end
        6'h0D: begin e.rf_we = 1; e.wa = 5'(rt); e.wd = a | zx; e.tag = "R4"; end
        6'h23: begin e.rf_we = 1; e.wa = 5'(rt); e.wd = m_dmem[ea[7:2]]; e.tag = "R5"; end
        6'h2B: begin
          e.dm_we = 1; e.da = ea; e.dd = b; e.tag = "R6";
          m_dmem[ea[7:2]] = b;
        end
        6'h04: begin
          e.tag = "R7";
          if (a == b) mpc = mpc + (sx << 2);
        end
        default: ;
      endcase
      if (e.rf_we && e.wa != 0) m_regs[e.wa] = e.wd;
      sb_q.push_back(e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_en && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "pc", pc, e.pc);
      check(e.tag, "rf_we", 32'(rf_we), 32'(e.rf_we));
      if (e.rf_we) begin
        check(e.tag, "rf_waddr", 32'(rf_waddr), 32'(e.wa));
        check(e.tag, "rf_wdata", rf_wdata, e.wd);
      end
      check(e.tag, "dm_we", 32'(dm_we), 32'(e.dm_we));
      if (e.dm_we) begin
        check(e.tag, "dm_addr", dm_addr, e.da);
        check(e.tag, "dm_wdata", dm_wdata, e.dd);
      end
    end
  end

  task automatic check_reset();
    @(negedge clk);
    // R1: reset state at the ports
    check("R1", "pc", pc, 32'h0);
    check("R1", "rf_we", 32'(rf_we), 32'h0);
    check("R1", "dm_we", 32'(dm_we), 32'h0);
  endtask

  // driver: load under reset, push expectations, run, re-enter reset
  task automatic run_prog(int cycles);
    for (int i = 0; i < prog.size(); i++) begin
      @(posedge clk); #2;
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
    end
    @(posedge clk); #2;
    prog_we = 1'b0;
    model_run(cycles);
    @(posedge clk); #2;
    rst_ni = 1'b1;
    mon_en = 1'b1;
    while (sb_q.size() != 0) @(negedge clk);
    @(posedge clk); #2;
    mon_en = 1'b0;
    rst_ni = 1'b0;
    check_reset();
  endtask

  initial begin
    #(20 * 100000);
    err_cnt++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    check_reset();

    // arithmetic, immediate, register 0, unknown encodings (R2 R3 R4 R8 R9)
    prog.delete();
    prog.push_back(enc_i(6'h0D, 0, 1, 16'h1234));
    prog.push_back(enc_i(6'h0D, 0, 2, 16'hFFFF));
    prog.push_back(enc_r(1, 2, 3, 6'h21));
    prog.push_back(enc_r(1, 2, 4, 6'h23));
    prog.push_back(enc_r(1, 1, 0, 6'h21));
    prog.push_back(enc_r(0, 1, 5, 6'h21));
    prog.push_back(enc_i(6'h0D, 4, 6, 16'h00F0));
    prog.push_back(enc_r(4, 4, 7, 6'h21));
    prog.push_back(enc_r(0, 2, 8, 6'h23));
    prog.push_back(enc_i(6'h3F, 1, 9, 16'h0005));
    prog.push_back(enc_r(1, 2, 10, 6'h20));
    prog.push_back(enc_r(10, 9, 11, 6'h21));
    prog.push_back(enc_i(6'h04, 0, 0, -1));
    run_prog(16);

    // loads, stores, branches (R5 R6 R7)
    prog.delete();
    prog.push_back(enc_i(6'h0D, 0, 1, 16'h0040));
    prog.push_back(enc_i(6'h0D, 0, 2, 16'hBEEF));
    prog.push_back(enc_i(6'h2B, 1, 2, 4));
    prog.push_back(enc_i(6'h2B, 1, 1, -4));
    prog.push_back(enc_i(6'h23, 1, 3, 4));
    prog.push_back(enc_i(6'h23, 1, 4, -4));
    prog.push_back(enc_r(3, 4, 5, 6'h21));
    prog.push_back(enc_i(6'h23, 0, 6, 16'h0044));
    prog.push_back(enc_i(6'h04, 3, 6, 2));
    prog.push_back(enc_i(6'h0D, 0, 7, 1));
    prog.push_back(enc_i(6'h0D, 0, 7, 2));
    prog.push_back(enc_i(6'h04, 1, 2, 5));
    prog.push_back(enc_i(6'h2B, 0, 5, 16'h0080));
    prog.push_back(enc_i(6'h23, 0, 12, 16'h0080));
    prog.push_back(enc_i(6'h04, 0, 0, -1));
    run_prog(18);

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end
endmodule